// File: doc/BRIEF.md
# Dual Word FIFO with Flush Control

This block holds a transmit queue and a receive queue of 32-bit words between a host register port and the engine of a serial bus controller. The host writes outgoing words to a data address and reads incoming words from another. The bus engine takes transmit words and delivers receive words through valid/ready handshakes. Each word carries four payload bytes, but this block does not pack or unpack bytes.

A control register holds two trigger levels and two flush bits. Each flush bit clears itself once its queue has been emptied, and the host can poll it at any time. A status byte reports free transmit slots in its upper nibble and filled receive entries in its lower nibble. A flag register combines two live data-request levels with sticky overflow and underflow errors, which are cleared by writing 1.

Top module: `dual_word_fifo`

## Requirements
- R1: Words written to the TX data address (3) leave on `tx_data` in write order. `tx_valid` is high while the TX queue holds a word. A word is removed in a cycle where both `tx_valid` and `tx_ready` are high.
- R2: Words accepted on `rx_valid && rx_ready` are returned in arrival order by reads of the RX data address (4). `rx_ready` is low while the RX queue holds DEPTH (8) words.
- R3: Writing 1 to control bit 1 (address 0) empties the TX queue, and bit 0 does the same for the RX queue. The bit reads 1 in the cycle after the write and 0 after that. The other queue is left unchanged.
- R4: A write to the TX data address while the TX queue is full is dropped and sets flag bit 5 (overflow). The queued words are unchanged.
- R5: A read of the RX data address while the RX queue is empty returns 0 and sets flag bit 4 (underflow).
- R6: Status (address 1): bits [7:4] give the free TX entries and bits [3:0] give the filled RX entries.
- R7: Flag bit 1 is high while free TX entries exceed control bits [7:5]. Flag bit 0 is high while filled RX entries exceed control bits [4:2]. Both bits follow the current counts.
- R8: Flag bits 4 and 5 stay set until 1 is written to that bit at the flag address (2). Writing 0 to them, or running a flush, leaves them set.
- R9: After reset both queues are empty and control reads 0. Status reads 0x80 and flags read 0x02 (`irq_flags` shows the same flag byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops the RX queue at address 4) |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 flags, 3 TX data, 4 RX data |
| reg_wdata | input | W | Host write data |
| reg_rdata | output | W | Host read data, combinational from the address |
| tx_valid | output | 1 | TX head word available to the engine |
| tx_ready | input | 1 | Engine takes the TX head word |
| tx_data | output | W | TX head word |
| rx_valid | input | 1 | Engine offers a received word |
| rx_ready | output | 1 | RX queue can accept a word |
| rx_data | input | W | Received word from the engine |
| irq_flags | output | 8 | Flag byte, the same value as the flag register |

## Verification
The hardest state to reach is a flush bit that is still busy. It lasts for a single cycle, so the stimulus writes the control register and reads it back in the very next cycle. A second read then shows the bit cleared and the status showing the queue empty. The overflow and underflow paths also require a queue to be filled or drained to its limit first. The stimulus then keeps one queue loaded while the other is flushed, which shows that a flush affects only its own queue and leaves the sticky flags untouched.

// File: rtl/dual_word_fifo_pkg.sv
package dual_word_fifo_pkg;
   localparam int TRIG_W = 3;

   typedef enum logic [2:0] {
      ADR_CTRL  = 3'd0,
      ADR_STAT  = 3'd1,
      ADR_FLAGS = 3'd2,
      ADR_TXD   = 3'd3,
      ADR_RXD   = 3'd4
   } dwf_addr_e;

   localparam int CTL_RX_FLUSH = 0;
   localparam int CTL_TX_FLUSH = 1;
   localparam int CTL_RX_TRIG  = 2;
   localparam int CTL_TX_TRIG  = 5;

   localparam int FLG_RX_REQ = 0;
   localparam int FLG_TX_REQ = 1;
   localparam int FLG_UNDER  = 4;
   localparam int FLG_OVER   = 5;
endpackage

// File: rtl/dwf_word_queue.sv
module dwf_word_queue #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0]     store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dwf_word_queue: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign do_push = push && (count != CNT_W'(DEPTH)) && !flush;
   assign do_pop  = pop  && (count != '0) && !flush;
   assign head    = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end
endmodule

// File: rtl/dwf_flag_unit.sv
module dwf_flag_unit #(
   parameter int CNT_W  = 4,
   parameter int TRIG_W = 3,
   localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tx_free,
   input  logic [CNT_W-1:0]  rx_fill,
   input  logic [TRIG_W-1:0] tx_trig,
   input  logic [TRIG_W-1:0] rx_trig,
   input  logic              set_over,
   input  logic              set_under,
   input  logic              clr_over,
   input  logic              clr_under,
   output logic [7:0]        flags
);
   import dual_word_fifo_pkg::*;

   logic over_q, under_q, tx_req, rx_req;

   assign tx_req = CMP_W'(tx_free) > CMP_W'(tx_trig);
   assign rx_req = CMP_W'(rx_fill) > CMP_W'(rx_trig);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         over_q  <= 1'b0;
         under_q <= 1'b0;
      end else begin
         over_q  <= set_over  | (over_q  & ~clr_over);
         under_q <= set_under | (under_q & ~clr_under);
      end
   end

   always_comb begin
      flags             = '0;
      flags[FLG_RX_REQ] = rx_req;
      flags[FLG_TX_REQ] = tx_req;
      flags[FLG_UNDER]  = under_q;
      flags[FLG_OVER]   = over_q;
   end
endmodule

// File: rtl/dual_word_fifo.sv
module dual_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr,
   input  logic         reg_rd,
   input  logic [2:0]   reg_addr,
   input  logic [W-1:0] reg_wdata,
   output logic [W-1:0] reg_rdata,
   output logic         tx_valid,
   input  logic         tx_ready,
   output logic [W-1:0] tx_data,
   input  logic         rx_valid,
   output logic         rx_ready,
   input  logic [W-1:0] rx_data,
   output logic [7:0]   irq_flags
);
   import dual_word_fifo_pkg::*;

   generate
      if (CNT_W > 4) begin : g_bad_cnt
         $error("dual_word_fifo: counts must fit a status nibble (DEPTH <= 15)");
      end
      if (W < 8) begin : g_bad_width
         $error("dual_word_fifo: W must hold a register byte");
      end
   endgenerate

   logic [TRIG_W-1:0] trig_tx, trig_rx;
   logic              pend_tx, pend_rx;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_free;
   logic [W-1:0]      rx_head;
   logic              wr_ctrl, wr_flags, wr_txd, rd_rxd;
   logic              tx_full, rx_empty, tx_push, tx_pop, rx_push, rx_pop;

   assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
   assign wr_flags = reg_wr && (reg_addr == ADR_FLAGS);
   assign wr_txd   = reg_wr && (reg_addr == ADR_TXD);
   assign rd_rxd   = reg_rd && (reg_addr == ADR_RXD);

   assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
   assign rx_empty = (rx_cnt == '0);
   assign tx_free  = CNT_W'(DEPTH) - tx_cnt;

   assign tx_push  = wr_txd && !tx_full && !pend_tx;
   assign tx_valid = (tx_cnt != '0) && !pend_tx;
   assign tx_pop   = tx_valid && tx_ready;
   assign rx_ready = (rx_cnt != CNT_W'(DEPTH)) && !pend_rx;
   assign rx_push  = rx_valid && rx_ready;
   assign rx_pop   = rd_rxd && !rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_tx <= '0;
         trig_rx <= '0;
         pend_tx <= 1'b0;
         pend_rx <= 1'b0;
      end else begin
         pend_tx <= wr_ctrl && reg_wdata[CTL_TX_FLUSH];
         pend_rx <= wr_ctrl && reg_wdata[CTL_RX_FLUSH];
         if (wr_ctrl) begin
            trig_tx <= reg_wdata[CTL_TX_TRIG +: TRIG_W];
            trig_rx <= reg_wdata[CTL_RX_TRIG +: TRIG_W];
         end
      end
   end

   dwf_word_queue #(.W(W), .DEPTH(DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .flush(pend_tx),
      .push(tx_push), .push_data(reg_wdata), .pop(tx_pop),
      .head(tx_data), .count(tx_cnt)
   );

   dwf_word_queue #(.W(W), .DEPTH(DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .flush(pend_rx),
      .push(rx_push), .push_data(rx_data), .pop(rx_pop),
      .head(rx_head), .count(rx_cnt)
   );

   dwf_flag_unit #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) i_flags (
      .clk(clk), .rst_n(rst_n),
      .tx_free(tx_free), .rx_fill(rx_cnt),
      .tx_trig(trig_tx), .rx_trig(trig_rx),
      .set_over(wr_txd && tx_full && !pend_tx),
      .set_under(rd_rxd && rx_empty),
      .clr_over(wr_flags && reg_wdata[FLG_OVER]),
      .clr_under(wr_flags && reg_wdata[FLG_UNDER]),
      .flags(irq_flags)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_CTRL:  reg_rdata = W'({trig_tx, trig_rx, pend_tx, pend_rx});
         ADR_STAT:  reg_rdata = W'({4'(tx_free), 4'(rx_cnt)});
         ADR_FLAGS: reg_rdata = W'(irq_flags);
         ADR_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dual_word_fifo_chk.sv
module dual_word_fifo_chk #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [2:0]       reg_addr,
   input logic [W-1:0]     reg_wdata,
   input logic [W-1:0]     reg_rdata,
   input logic             rx_ready,
   input logic [7:0]       irq_flags,
   input logic [CNT_W-1:0] tx_cnt,
   input logic [CNT_W-1:0] rx_cnt,
   input logic             pend_tx
);
   import dual_word_fifo_pkg::*;

   a_r3_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTL_TX_FLUSH]) |=> ##1 (tx_cnt == '0));

   a_r3_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTL_RX_FLUSH]) |=> ##1 (rx_cnt == '0));

   a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_TXD && tx_cnt == CNT_W'(DEPTH) && !pend_tx)
      |=> (irq_flags[FLG_OVER] && tx_cnt == CNT_W'(DEPTH)));

   a_r5_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADR_RXD && rx_cnt == '0) |-> (reg_rdata == '0));

   a_r5_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADR_RXD && rx_cnt == '0) |=> irq_flags[FLG_UNDER]);

   a_r8_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags[FLG_OVER] && !(reg_wr && reg_addr == ADR_FLAGS && reg_wdata[FLG_OVER]))
      |=> irq_flags[FLG_OVER]);

   a_r2_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CNT_W'(DEPTH)) |-> !rx_ready);
endmodule

bind dual_word_fifo dual_word_fifo_chk #(.W(W), .DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .rx_ready(rx_ready), .irq_flags(irq_flags),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .pend_tx(pend_tx)
);

// File: tb/test_dual_word_fifo.sv
module test_dual_word_fifo;
   localparam int W = 32;
   localparam int NVEC = 20;
   // {op[1:0], addr[2:0], data[31:0], exp[31:0]}; op 0 write, 1 read, 2 rx push, 3 tx pop
   localparam logic [68:0] VEC [NVEC] = '{
      {2'd1, 3'd1, 32'h0,      32'h80},
      {2'd1, 3'd2, 32'h0,      32'h02},
      {2'd1, 3'd0, 32'h0,      32'h00},
      {2'd0, 3'd3, 32'hA1,     32'h0},
      {2'd0, 3'd3, 32'hB2,     32'h0},
      {2'd1, 3'd1, 32'h0,      32'h60},
      {2'd3, 3'd0, 32'h0,      32'hA1},
      {2'd3, 3'd0, 32'h0,      32'hB2},
      {2'd2, 3'd0, 32'h1111,   32'h0},
      {2'd2, 3'd0, 32'h2222,   32'h0},
      {2'd2, 3'd0, 32'h3333,   32'h0},
      {2'd1, 3'd1, 32'h0,      32'h83},
      {2'd1, 3'd2, 32'h0,      32'h03},
      {2'd0, 3'd0, 32'hE8,     32'h0},
      {2'd1, 3'd2, 32'h0,      32'h03},
      {2'd1, 3'd4, 32'h0,      32'h1111},
      {2'd1, 3'd2, 32'h0,      32'h02},
      {2'd1, 3'd4, 32'h0,      32'h2222},
      {2'd1, 3'd4, 32'h0,      32'h3333},
      {2'd1, 3'd1, 32'h0,      32'h80}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         tx_valid, tx_ready = 1'b0;
   logic [W-1:0] tx_data;
   logic         rx_valid = 1'b0, rx_ready;
   logic [W-1:0] rx_data = '0;
   logic [7:0]   irq_flags;
   int           checks = 0, fails = 0;

   always #10 clk = ~clk;

   dual_word_fifo i_dual_word_fifo (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .irq_flags(irq_flags)
   );

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic host_wr(logic [2:0] a, logic [W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic host_rd(logic [2:0] a, logic [W-1:0] exp, string req);
      reg_rd = 1'b1; reg_addr = a;
      #1 check(req, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic eng_push(logic [W-1:0] d);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic eng_pop(logic [W-1:0] exp);
      tx_ready = 1'b1;
      #1 check("R1 tx_valid", W'(tx_valid), W'(1));
      check("R1 tx_data", tx_data, exp);
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   function automatic string rd_req(logic [2:0] a);
      case (a)
         3'd0: return "R9 control";
         3'd1: return "R6 status";
         3'd2: return "R7 flags";
         default: return "R2 rx data";
      endcase
   endfunction

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state at the ports
      check("R9 tx_valid", W'(tx_valid), W'(0));
      check("R9 rx_ready", W'(rx_ready), W'(1));
      check("R9 irq_flags", W'(irq_flags), W'(8'h02));

      for (int i = 0; i < NVEC; i++) begin
         case (VEC[i][68:67])
            2'd0: host_wr(VEC[i][66:64], VEC[i][63:32]);
            2'd1: host_rd(VEC[i][66:64], VEC[i][31:0], rd_req(VEC[i][66:64]));
            2'd2: eng_push(VEC[i][63:32]);
            default: eng_pop(VEC[i][31:0]);
         endcase
      end

      // R4 fill TX, then overflow (tx trigger is 7, rx trigger 2)
      for (int i = 0; i < 8; i++) host_wr(3'd3, W'(32'h100 + i));
      host_rd(3'd1, 32'h00, "R6 tx full status");
      host_rd(3'd2, 32'h00, "R7 tx request off when full");
      host_wr(3'd3, 32'hDEAD);
      host_rd(3'd2, 32'h20, "R4 overflow flag");
      host_rd(3'd1, 32'h00, "R4 dropped write keeps count");
      eng_pop(32'h100);

      // R3 TX flush busy bit and self clear
      host_wr(3'd0, 32'hEA);
      host_rd(3'd0, 32'hEA, "R3 tx flush busy");
      host_rd(3'd0, 32'hE8, "R3 tx flush cleared");
      host_rd(3'd1, 32'h80, "R3 tx emptied");
      check("R3 tx_valid after flush", W'(tx_valid), W'(0));
      host_rd(3'd2, 32'h22, "R8 flush keeps overflow");

      // R3 RX flush leaves TX alone
      host_wr(3'd3, 32'h55);
      eng_push(32'h66);
      eng_push(32'h77);
      host_wr(3'd0, 32'hE9);
      host_rd(3'd0, 32'hE9, "R3 rx flush busy");
      host_rd(3'd1, 32'h70, "R3 rx emptied, tx kept");
      eng_pop(32'h55);

      // R5 underflow
      host_rd(3'd4, 32'h0, "R5 empty read returns 0");
      host_rd(3'd2, 32'h32, "R5 underflow flag");

      // R8 write-one-to-clear
      host_wr(3'd2, 32'h00);
      host_rd(3'd2, 32'h32, "R8 zero write keeps flags");
      host_wr(3'd2, 32'h10);
      host_rd(3'd2, 32'h22, "R8 clear underflow");
      host_wr(3'd2, 32'h20);
      host_rd(3'd2, 32'h02, "R8 clear overflow");

      // R2 RX full back-pressure
      host_wr(3'd0, 32'h00);
      for (int i = 0; i < 8; i++) eng_push(W'(32'h200 + i));
      check("R2 rx_ready low when full", W'(rx_ready), W'(0));
      host_rd(3'd1, 32'h88, "R6 rx full status");
      host_rd(3'd2, 32'h03, "R7 both requests");
      host_rd(3'd4, 32'h200, "R2 first rx word");
      host_rd(3'd1, 32'h87, "R6 after rx read");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule